// File: doc/BRIEF.md
# Coprocessor Accumulator Transfer Unit

This block recognises the 32-bit coprocessor two-register transfer instruction words that target the internal accumulator. It moves data between a pair of general-purpose register values and a single 40-bit accumulator. The issue stage presents the instruction word, the current N/Z/C/V flags, the access-enable bit from the coprocessor access register and the two source register values, together with an issue strobe.

A move-to packs the low-word register and the low byte of the high-word register into the accumulator. A move-from returns the accumulator's low 32 bits, plus its top byte sign-extended to 32 bits, along with the two destination register indices, so the register file can write them back. An access that is illegal raises a one-cycle undefined-instruction flag and changes nothing. An access is illegal when access is disabled, when a reserved field is nonzero, or when it names an accumulator other than number 0.

Top module: `acc_xfer_unit`

## Requirements
- R1: A word is an accumulator transfer only when bits 27:21 equal 7'b1100010. Any other word causes no accumulator change, no read write-back (`rd_we_o` low) and no undefined flag.
- R2: Bits 31:28 are a condition code evaluated on `flags_i` = {N,Z,C,V}. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), and 14 always. A failing condition performs no transfer and raises no undefined flag.
- R3: With bit 20 = 0, a legal, condition-passing issue loads the accumulator on the next rising edge. Bits 39:32 take `src_hi_i[7:0]` and bits 31:0 take `src_lo_i`. Bits 31:8 of `src_hi_i` are ignored.
- R4: With bit 20 = 1, a legal, condition-passing issue raises `rd_we_o` in the same cycle. In that cycle `rd_lo_o` = acc[31:0] and `rd_hi_o` = acc[39:32] sign-extended to 32 bits. The destination indices are `dst_hi_o` = bits 19:16 and `dst_lo_o` = bits 15:12.
- R5: When `cp_access_i` is 0, a recognised, condition-passing issue raises `undef_o` in that cycle only, and performs no transfer.
- R6: When any of bits 11:3 is nonzero, a recognised, condition-passing issue raises `undef_o` and performs no transfer.
- R7: When the accumulator index in bits 2:0 is nonzero, a recognised, condition-passing issue raises `undef_o` and performs no transfer.
- R8: A synchronous active-high `rst` clears the accumulator to zero.
- R9: Condition code 4'b1111 never executes. It performs no transfer and raises no undefined flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction issue strobe |
| insn_i | input | 32 | Instruction word |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| cp_access_i | input | 1 | Accumulator access enable (access register bit 0) |
| src_hi_i | input | 32 | High-word source register value |
| src_lo_i | input | 32 | Low-word source register value |
| dst_hi_o | output | 4 | High-word destination register index |
| dst_lo_o | output | 4 | Low-word destination register index |
| rd_hi_o | output | 32 | Sign-extended accumulator bits 39:32 |
| rd_lo_o | output | 32 | Accumulator bits 31:0 |
| rd_we_o | output | 1 | Read results valid for write-back |
| undef_o | output | 1 | Undefined-instruction flag |

## Verification
The read data, write-back strobe, destination indices and undefined flag are combinational from the issue inputs and the accumulator. They are due in the same cycle as the strobe. A move-to changes the accumulator only at the next rising edge, so its effect is visible to a read issued in the following cycle. The driver applies each instruction just after a falling edge and queues the expected outcome. The monitor checks the outputs two nanoseconds later, well before the next rising edge, so every comparison sees a settled same-cycle result. Writes, rejected words and resets are judged by the value that a later read brings out.

// File: rtl/acc_xfer_pkg.sv
package acc_xfer_pkg;
  localparam int XLEN   = 32;
  localparam int ACC_W  = 40;
  localparam int HI_W   = ACC_W - XLEN;
  localparam int N_ACC  = 8;
  localparam int IDX_W  = $clog2(N_ACC);
  localparam logic [6:0] XFER_OPC = 7'b1100010;

  typedef struct packed {
    logic [3:0] cond;
    logic       hit;
    logic       to_regs;
    logic [3:0] hi_idx;
    logic [3:0] lo_idx;
    logic       sbz_ok;
    logic       acc_ok;
  } dec_t;

  // Condition evaluation over flags {N,Z,C,V}
  function automatic logic cond_eval(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cf, v;
    {n, z, cf, v} = f;
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cf;
      4'h3: return !cf;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cf && !z;
      4'h9: return !cf || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] pack_wr(input logic [XLEN-1:0] hi,
                                               input logic [XLEN-1:0] lo);
    return {hi[HI_W-1:0], lo};
  endfunction

  function automatic logic [XLEN-1:0] sext_hi(input logic [HI_W-1:0] b);
    return {{(XLEN-HI_W){b[HI_W-1]}}, b};
  endfunction
endpackage

// File: rtl/acc_xfer_decode.sv
module acc_xfer_decode
  import acc_xfer_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output dec_t            dec
);
  always_comb begin
    dec.cond    = insn[31:28];
    dec.hit     = (insn[27:21] == XFER_OPC);
    dec.to_regs = insn[20];
    dec.hi_idx  = insn[19:16];
    dec.lo_idx  = insn[15:12];
    dec.sbz_ok  = (insn[11:IDX_W] == '0);
    dec.acc_ok  = (insn[IDX_W-1:0] == '0);
  end
endmodule

// File: rtl/acc_xfer_cond.sv
module acc_xfer_cond
  import acc_xfer_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       pass
);
  assign pass = cond_eval(cond, flags);
endmodule

// File: rtl/acc_xfer_store.sv
module acc_xfer_store
  import acc_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [XLEN-1:0]  hi,
  input  logic [XLEN-1:0]  lo,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (we) acc <= pack_wr(hi, lo);
  end
endmodule

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit
  import acc_xfer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic [XLEN-1:0] insn_i,
  input  logic [3:0]      flags_i,
  input  logic            cp_access_i,
  input  logic [XLEN-1:0] src_hi_i,
  input  logic [XLEN-1:0] src_lo_i,
  output logic [3:0]      dst_hi_o,
  output logic [3:0]      dst_lo_o,
  output logic [XLEN-1:0] rd_hi_o,
  output logic [XLEN-1:0] rd_lo_o,
  output logic            rd_we_o,
  output logic            undef_o
);
  dec_t             dec;
  logic             cond_pass;
  logic             legal;
  logic             fire;
  logic             wr_fire;
  logic [ACC_W-1:0] acc_q;

  acc_xfer_decode u_dec (.insn(insn_i), .dec(dec));

  acc_xfer_cond u_cond (.cond(dec.cond), .flags(flags_i), .pass(cond_pass));

  // Named events for the checker
  assign legal   = cp_access_i && dec.sbz_ok && dec.acc_ok;
  assign fire    = issue_i && dec.hit && cond_pass;
  assign wr_fire = fire && legal && !dec.to_regs;

  acc_xfer_store u_acc (
    .clk(clk), .rst(rst), .we(wr_fire),
    .hi(src_hi_i), .lo(src_lo_i), .acc(acc_q)
  );

  assign rd_we_o  = fire && legal && dec.to_regs;
  assign undef_o  = fire && !legal;
  assign dst_hi_o = dec.hi_idx;
  assign dst_lo_o = dec.lo_idx;
  assign rd_lo_o  = acc_q[XLEN-1:0];
  assign rd_hi_o  = sext_hi(acc_q[ACC_W-1:XLEN]);
endmodule

// File: rtl/acc_xfer_chk.sv
module acc_xfer_chk
  import acc_xfer_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic [XLEN-1:0]  insn_i,
  input logic [XLEN-1:0]  src_hi_i,
  input logic [XLEN-1:0]  src_lo_i,
  input logic [XLEN-1:0]  rd_hi_o,
  input logic [XLEN-1:0]  rd_lo_o,
  input logic             rd_we_o,
  input logic             undef_o,
  input logic             wr_fire,
  input logic             fire,
  input logic [ACC_W-1:0] acc_q
);
  p_unrec_r1: assert property (@(posedge clk) disable iff (rst)
    (issue_i && insn_i[27:21] != 7'b1100010) |-> (!undef_o && !rd_we_o && !wr_fire));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (acc_q[XLEN-1:0] == $past(src_lo_i)
                 && acc_q[ACC_W-1:XLEN] == $past(src_hi_i[HI_W-1:0])));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(acc_q));

  p_sext_r4: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> (rd_lo_o == acc_q[XLEN-1:0] && rd_hi_o[HI_W-1:0] == acc_q[ACC_W-1:XLEN]
                 && (rd_hi_o[XLEN-1:HI_W] == '0 || rd_hi_o[XLEN-1:HI_W] == '1)));

  p_undef_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (!rd_we_o && !wr_fire && fire));

  p_badidx_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && insn_i[IDX_W-1:0] != '0) |-> undef_o);

  p_badsbz_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && insn_i[11:IDX_W] != '0) |-> undef_o);

  p_never_r9: assert property (@(posedge clk) disable iff (rst)
    (issue_i && insn_i[31:28] == 4'hF) |-> (!undef_o && !rd_we_o && !wr_fire));

  p_clear_r8: assert property (@(posedge clk)
    rst |=> (acc_q == '0));
endmodule

bind acc_xfer_unit acc_xfer_chk u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .insn_i(insn_i),
  .src_hi_i(src_hi_i), .src_lo_i(src_lo_i),
  .rd_hi_o(rd_hi_o), .rd_lo_o(rd_lo_o), .rd_we_o(rd_we_o), .undef_o(undef_o),
  .wr_fire(wr_fire), .fire(fire), .acc_q(acc_q)
);

// File: tb/sim_acc_xfer_unit.sv
`timescale 1ns/1ps
module sim_acc_xfer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [3:0]  flags_i = '0;
  logic        cp_access_i = 1'b1;
  logic [31:0] src_hi_i = '0, src_lo_i = '0;
  logic [3:0]  dst_hi_o, dst_lo_o;
  logic [31:0] rd_hi_o, rd_lo_o;
  logic        rd_we_o, undef_o;

  always #5 clk = ~clk;

  acc_xfer_unit u0 (
    .clk(clk), .rst(rst), .issue_i(issue_i), .insn_i(insn_i), .flags_i(flags_i),
    .cp_access_i(cp_access_i), .src_hi_i(src_hi_i), .src_lo_i(src_lo_i),
    .dst_hi_o(dst_hi_o), .dst_lo_o(dst_lo_o), .rd_hi_o(rd_hi_o), .rd_lo_o(rd_lo_o),
    .rd_we_o(rd_we_o), .undef_o(undef_o)
  );

  typedef struct {
    string       req;
    logic        undef;
    logic        we;
    logic [31:0] hi, lo;
    logic [3:0]  hidx, lidx;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [39:0] acc_m = '0;
  bit          done = 0;

  // Bench-side condition model: pick base flag term, odd code inverts it
  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit b;
    case (c[3:1])
      3'd0: b = f[2];
      3'd1: b = f[1];
      3'd2: b = f[3];
      3'd3: b = f[0];
      3'd4: b = f[1] & ~f[2];
      3'd5: b = (f[3] == f[0]);
      3'd6: b = ~f[2] & (f[3] == f[0]);
      default: b = 1'b1;
    endcase
    return c[0] ? !b : b;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] c, input bit l,
                                     input logic [3:0] rh, input logic [3:0] rl,
                                     input logic [8:0] sbz, input logic [2:0] a);
    return {c, 7'b1100010, l, rh, rl, sbz, a};
  endfunction

  // Driver: one instruction per cycle, expected outcome pushed to the scoreboard
  task automatic drive(input string req, input logic [31:0] w, input logic [3:0] f,
                       input bit en, input logic [31:0] hi, input logic [31:0] lo);
    item_t it;
    bit recog, pass, legal;
    @(negedge clk);
    issue_i = 1'b1; insn_i = w; flags_i = f; cp_access_i = en;
    src_hi_i = hi; src_lo_i = lo;
    recog = (w[27:21] == 7'b1100010);
    pass  = recog && cond_ok(w[31:28], f);
    legal = en && (w[11:0] == 12'h000 || (w[11:3] == 9'h0 && w[2:0] == 3'h0));
    it.req   = req;
    it.undef = pass && !legal;
    it.we    = pass && legal && w[20];
    it.hi    = {{24{acc_m[39]}}, acc_m[39:32]};
    it.lo    = acc_m[31:0];
    it.hidx  = w[19:16];
    it.lidx  = w[15:12];
    sb_q.push_back(it);
    if (pass && legal && !w[20]) acc_m = {hi[7:0], lo};
  endtask

  task automatic rd(input string req, input logic [3:0] rh, input logic [3:0] rl);
    drive(req, mk(4'hE, 1'b1, rh, rl, 9'h0, 3'h0), 4'h0, 1'b1, 32'h0, 32'h0);
  endtask

  task automatic wr(input string req, input logic [31:0] hi, input logic [31:0] lo);
    drive(req, mk(4'hE, 1'b0, 4'h1, 4'h2, 9'h0, 3'h0), 4'h0, 1'b1, hi, lo);
  endtask

  // Monitor: compares settled same-cycle outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t e;
        bit bad;
        e = sb_q.pop_front();
        checks++;
        bad = (undef_o !== e.undef) || (rd_we_o !== e.we);
        if (e.we) bad = bad || (rd_hi_o !== e.hi) || (rd_lo_o !== e.lo)
                            || (dst_hi_o !== e.hidx) || (dst_lo_o !== e.lidx);
        if (bad) begin
          errors++;
          $display("FAIL %s: got undef=%0b we=%0b hi=%h lo=%h dh=%0d dl=%0d exp undef=%0b we=%0b hi=%h lo=%h dh=%0d dl=%0d",
                   e.req, undef_o, rd_we_o, rd_hi_o, rd_lo_o, dst_hi_o, dst_lo_o,
                   e.undef, e.we, e.hi, e.lo, e.hidx, e.lidx);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd("R8 reset state", 4'h3, 4'h4);
    wr("R3 write", 32'hABCD_127F, 32'hDEAD_BEEF);
    rd("R4 read positive", 4'h5, 4'h6);
    wr("R3 write neg byte", 32'h0000_0080, 32'h0123_4567);
    rd("R4 read sign-extended", 4'hF, 4'h0);
    // R1: opcode bit flipped, must be ignored
    drive("R1 unrecognised", mk(4'hE, 1'b0, 4'h1, 4'h2, 9'h0, 3'h0) ^ 32'h0020_0000,
          4'h0, 1'b1, 32'h11, 32'h2222);
    drive("R1 unrecognised", mk(4'hE, 1'b1, 4'h1, 4'h2, 9'h0, 3'h0) ^ 32'h0800_0000,
          4'h0, 1'b1, 32'h0, 32'h0);
    rd("R1 state unchanged", 4'h7, 4'h8);
    // R5: access disabled
    drive("R5 access off write", mk(4'hE, 1'b0, 4'h1, 4'h2, 9'h0, 3'h0), 4'h0, 1'b0,
          32'h55, 32'h5555_5555);
    drive("R5 access off read", mk(4'hE, 1'b1, 4'h1, 4'h2, 9'h0, 3'h0), 4'h0, 1'b0,
          32'h0, 32'h0);
    rd("R5 state unchanged", 4'h9, 4'hA);
    // R6: reserved bits
    drive("R6 bit3 set", mk(4'hE, 1'b0, 4'h1, 4'h2, 9'h001, 3'h0), 4'h0, 1'b1,
          32'h66, 32'h6666_6666);
    drive("R6 bit11 set", mk(4'hE, 1'b1, 4'h1, 4'h2, 9'h100, 3'h0), 4'h0, 1'b1,
          32'h0, 32'h0);
    rd("R6 state unchanged", 4'hB, 4'hC);
    // R7: nonzero accumulator index
    drive("R7 acc index 3 write", mk(4'hE, 1'b0, 4'h1, 4'h2, 9'h0, 3'h3), 4'h0, 1'b1,
          32'h77, 32'h7777_7777);
    drive("R7 acc index 7 read", mk(4'hE, 1'b1, 4'h1, 4'h2, 9'h0, 3'h7), 4'h0, 1'b1,
          32'h0, 32'h0);
    rd("R7 state unchanged", 4'hD, 4'hE);
    // R2: failing condition masks an illegal access (EQ with Z clear)
    drive("R2 failing cond no undef", mk(4'h0, 1'b0, 4'h1, 4'h2, 9'h0, 3'h5), 4'h0, 1'b0,
          32'h0, 32'h0);
    // R2/R9: all codes over several flag patterns
    for (int fp = 0; fp < 16; fp += 3) begin
      for (int c = 0; c < 16; c++) begin
        drive((c == 15) ? "R9 never code" : "R2 condition write",
              mk(c[3:0], 1'b0, 4'h3, 4'h4, 9'h0, 3'h0), fp[3:0], 1'b1,
              {24'h0, 4'(c), 4'(fp)}, 32'hC0DE_0000 + (fp << 8) + c);
        rd((c == 15) ? "R9 never code result" : "R2 condition result", 4'h3, 4'h4);
        drive((c == 15) ? "R9 never code read" : "R2 condition read",
              mk(c[3:0], 1'b1, 4'h2, 4'h1, 9'h0, 3'h0), fp[3:0], 1'b1, 32'h0, 32'h0);
      end
    end
    // R8: reset in mid-run
    wr("R3 write before reset", 32'h0000_00C3, 32'hFFFF_0000);
    rd("R4 read before reset", 4'h1, 4'h2);
    @(negedge clk);
    issue_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    acc_m = '0;
    rd("R8 cleared by reset", 4'h1, 4'h2);
    @(negedge clk);
    issue_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule